// File: doc/BRIEF.md
# Four-Port Receive Frame Readout

This block buffers received Ethernet frame words for four ports and hands them to a host over one 32-bit synchronous read path. Each port has its own small word FIFO. The FIFO is loaded through a word-wide write port that carries a data word, active-low lane strobes and a last-word marker. The host raises a read strobe together with a port number. One clock edge later the block presents a word with its lane strobes, a valid bit and an end-of-frame tag.

After the last data word of a frame, the block can insert a status word that carries the frame's byte count and an error bit. Two configuration inputs choose how frame ends are marked:

- The status word alone carries the end-of-frame tag.
- Both the last data word and the status word carry the tag.
- No status word is sent, and the last data word carries the tag.

Each port has a registered ready output that rises when its fill level passes a per-port threshold. Each port also has a sticky error output that catches illegal lane-strobe patterns arriving on its write side.

Top module: `rx_frame_reader`

## Requirements
- R1: Data words of a port come out in the order they were written, unchanged, with `rd_valid` high. Reads of one port do not disturb any other port. Every data word other than the last word of a frame comes out with `rd_ben_n` = 4'b0000 and `rd_eof` low. Lane strobes are active low: bit k low means byte lane k (bits 8k+7:8k) is valid.
- R2: On the last data word of a frame, `rd_ben_n` is set by the frame byte count modulo 4, packed from lane 0 upward. Remainder 0 gives 4'b0000, 1 gives 4'b1110, 2 gives 4'b1100 and 3 gives 4'b1000.
- R3: With `cfg_eof_both`=0 and `cfg_no_status`=0, `rd_eof` is high only on the status word. It is low on the last data word.
- R4: With `cfg_eof_both`=1 and `cfg_no_status`=0, `rd_eof` is high on both the last data word and the following status word.
- R5: With `cfg_no_status`=1, no status word is produced and `rd_eof` is high on the last data word. This holds for either value of `cfg_eof_both`.
- R6: When enabled, the status word is the next word returned by a read of that port after its last data word. It holds the frame byte count in bits [15:0] and the frame error bit in bit 16. All other bits are zero, and `rd_ben_n` = 4'b0000.
- R7: A valid output word never carries `rd_ben_n` = 4'b1111.
- R8: A written word whose strobes are 4'b1111 sets that port's `err_sticky` bit, which holds until reset. The word contributes no bytes to the frame count, and the frame's status error bit is 1.
- R9: A read of a port that has neither a stored word nor a pending status word leaves `rd_valid` low. It consumes nothing, so the next word written to that port is the next one read.
- R10: `rx_ready[p]` is high one edge after the fill level of port p is strictly greater than its threshold, and low otherwise.
- R11: Reset empties every FIFO and drops any pending status. It also clears `rx_ready`, `rd_valid`, `rd_eof`, `wr_full` and `err_sticky`.
- R12: `wr_full[p]` is high while port p holds FIFO_DEPTH words. A write to a full port is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_eof_both | input | 1 | Tag the last data word as well as the status word |
| cfg_no_status | input | 1 | Suppress status words; tag the last data word |
| wr_en | input | NUM_PORTS | Per-port write strobe |
| wr_data | input | 32*NUM_PORTS | Per-port write word, port p at bits [32p+31:32p] |
| wr_ben_n | input | 4*NUM_PORTS | Per-port active-low lane strobes |
| wr_last | input | NUM_PORTS | Word is the last of its frame |
| rx_thresh | input | FILL_W*NUM_PORTS | Per-port ready threshold |
| wr_full | output | NUM_PORTS | Port FIFO is full |
| rd_en | input | 1 | Host read strobe |
| rd_port | input | PSEL_W | Port to read |
| rd_data | output | 32 | Read word |
| rd_ben_n | output | 4 | Active-low lane strobes of the read word |
| rd_eof | output | 1 | End-of-frame tag |
| rd_valid | output | 1 | Read word is valid |
| rx_ready | output | NUM_PORTS | Fill-level watermark per port |
| err_sticky | output | NUM_PORTS | Illegal strobe pattern seen on a port |

## Verification
The bench uses the default parameters: four ports and an eight-word FIFO, which makes FILL_W four bits. Eight words is shallow enough for one 32-byte frame to fill a port. That brings the full flag and a discarded extra write into reach without long stimulus. Four ports allow reads to be interleaved across ports while status words are pending. Setting one threshold to 2 lets the watermark be crossed in both directions with a few words. A threshold of 8 on the other ports keeps their ready outputs low.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int BCNT_W  = 16;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic [BCNT_W-1:0] bcnt;
        logic              ferr;
    } rxr_entry_t;

    typedef struct packed {
        logic [BCNT_W-1:0] bcnt;
        logic              ferr;
    } rxr_stat_t;

    typedef enum logic [1:0] {
        EOF_STAT_ONLY,
        EOF_DATA_AND_STAT,
        EOF_DATA_ONLY
    } rxr_eof_mode_e;

    function automatic rxr_eof_mode_e eof_mode(input logic both, input logic no_stat);
        if (no_stat)   return EOF_DATA_ONLY;
        else if (both) return EOF_DATA_AND_STAT;
        else           return EOF_STAT_ONLY;
    endfunction

    // Active-low lane strobes for the tail word, packed from lane 0.
    function automatic logic [LANES-1:0] tail_ben_n(input logic [1:0] rem);
        logic [LANES-1:0] b;
        case (rem)
            2'd1:    b = 4'b1110;
            2'd2:    b = 4'b1100;
            2'd3:    b = 4'b1000;
            default: b = 4'b0000;
        endcase
        return b;
    endfunction

    function automatic logic [2:0] lane_count(input logic [LANES-1:0] ben_n);
        logic [2:0] c;
        c = '0;
        for (int i = 0; i < LANES; i++) c = c + {2'b00, ~ben_n[i]};
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input rxr_stat_t s);
        return {{(DATA_W-BCNT_W-1){1'b0}}, s.ferr, s.bcnt};
    endfunction

endpackage

// File: rtl/rxr_frame_acc.sv
module rxr_frame_acc
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_ben_n,
    input  logic              wr_last,
    input  logic              fifo_full,
    output logic              push,
    output rxr_entry_t        push_entry,
    output logic              err_sticky
);
    logic [BCNT_W-1:0] acc;
    logic              frame_err;
    logic              accept;
    logic              illegal;
    logic [2:0]        add;
    logic [BCNT_W-1:0] total;
    logic              ferr_now;

    always_comb begin
        accept   = wr_en && !fifo_full;
        illegal  = &wr_ben_n;
        add      = illegal ? 3'd0 : lane_count(wr_ben_n);
        total    = acc + BCNT_W'(add);
        ferr_now = frame_err | illegal;
        push     = accept;
        push_entry.data = wr_data;
        push_entry.last = wr_last;
        push_entry.bcnt = total;
        push_entry.ferr = ferr_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            frame_err  <= 1'b0;
            err_sticky <= 1'b0;
        end else if (accept) begin
            if (wr_last) begin
                acc       <= '0;
                frame_err <= 1'b0;
            end else begin
                acc       <= total;
                frame_err <= ferr_now;
            end
            if (illegal) err_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/rxr_port_fifo.sv
module rxr_port_fifo
    import rxr_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int FW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  rxr_entry_t push_entry,
    input  logic       pop,
    output rxr_entry_t head,
    output logic       empty,
    output logic       full,
    output logic [FW-1:0] fill
);
    rxr_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (fill == '0);
        full    = (fill == FW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/rxr_watermark.sv
module rxr_watermark #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] fill,
    input  logic [FW-1:0] thresh,
    output logic          ready
);
    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b0;
        else     ready <= (fill > thresh);
    end
endmodule

// File: rtl/rxr_readout.sv
module rxr_readout
    import rxr_pkg::*;
#(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [PW-1:0]     rd_port,
    input  logic              cfg_eof_both,
    input  logic              cfg_no_status,
    input  rxr_entry_t        head [NP],
    input  logic [NP-1:0]     empty,
    output logic [NP-1:0]     pop,
    output logic [NP-1:0]     pend_o,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  rd_ben_n,
    output logic              rd_eof,
    output logic              rd_valid
);
    logic [NP-1:0] pend;
    rxr_stat_t     pst [NP];
    rxr_eof_mode_e mode;
    rxr_entry_t    cur;
    logic          cur_pend;
    logic          cur_pop;

    always_comb begin
        mode     = eof_mode(cfg_eof_both, cfg_no_status);
        cur      = head[rd_port];
        cur_pend = pend[rd_port];
        cur_pop  = rd_en && !cur_pend && !empty[rd_port];
        pend_o   = pend;
    end

    for (genvar i = 0; i < NP; i++) begin : g_pop
        assign pop[i] = rd_en && (rd_port == PW'(i)) && !pend[i] && !empty[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            rd_valid <= 1'b0;
            rd_eof   <= 1'b0;
            rd_ben_n <= '0;
            rd_data  <= '0;
            for (int i = 0; i < NP; i++) pst[i] <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_eof   <= 1'b0;
            rd_ben_n <= '0;
            rd_data  <= '0;
            if (rd_en && cur_pend) begin
                rd_valid      <= 1'b1;
                rd_data       <= stat_word(pst[rd_port]);
                rd_eof        <= 1'b1;
                pend[rd_port] <= 1'b0;
            end else if (cur_pop) begin
                rd_valid <= 1'b1;
                rd_data  <= cur.data;
                if (cur.last) begin
                    rd_ben_n <= tail_ben_n(cur.bcnt[1:0]);
                    rd_eof   <= (mode != EOF_STAT_ONLY);
                    if (mode != EOF_DATA_ONLY) begin
                        pend[rd_port]     <= 1'b1;
                        pst[rd_port].bcnt <= cur.bcnt;
                        pst[rd_port].ferr <= cur.ferr;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rx_frame_reader.sv
module rx_frame_reader
    import rxr_pkg::*;
#(
    parameter  int NUM_PORTS  = 4,
    parameter  int FIFO_DEPTH = 8,
    localparam int PSEL_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_eof_both,
    input  logic                          cfg_no_status,
    input  logic [NUM_PORTS-1:0]          wr_en,
    input  logic [NUM_PORTS*DATA_W-1:0]   wr_data,
    input  logic [NUM_PORTS*LANES-1:0]    wr_ben_n,
    input  logic [NUM_PORTS-1:0]          wr_last,
    input  logic [NUM_PORTS*FILL_W-1:0]   rx_thresh,
    output logic [NUM_PORTS-1:0]          wr_full,
    input  logic                          rd_en,
    input  logic [PSEL_W-1:0]             rd_port,
    output logic [DATA_W-1:0]             rd_data,
    output logic [LANES-1:0]              rd_ben_n,
    output logic                          rd_eof,
    output logic                          rd_valid,
    output logic [NUM_PORTS-1:0]          rx_ready,
    output logic [NUM_PORTS-1:0]          err_sticky
);
    rxr_entry_t                  fifo_head [NUM_PORTS];
    logic [NUM_PORTS-1:0]        fifo_empty;
    logic [NUM_PORTS-1:0]        fifo_pop;
    logic [NUM_PORTS-1:0]        stat_pend;
    logic [NUM_PORTS*FILL_W-1:0] fill_flat;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic       push;
        rxr_entry_t push_entry;

        rxr_frame_acc u_acc (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_en[g]),
            .wr_data    (wr_data[g*DATA_W +: DATA_W]),
            .wr_ben_n   (wr_ben_n[g*LANES +: LANES]),
            .wr_last    (wr_last[g]),
            .fifo_full  (wr_full[g]),
            .push       (push),
            .push_entry (push_entry),
            .err_sticky (err_sticky[g])
        );

        rxr_port_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push       (push),
            .push_entry (push_entry),
            .pop        (fifo_pop[g]),
            .head       (fifo_head[g]),
            .empty      (fifo_empty[g]),
            .full       (wr_full[g]),
            .fill       (fill_flat[g*FILL_W +: FILL_W])
        );

        rxr_watermark #(.FW(FILL_W)) u_wm (
            .clk    (clk),
            .rst    (rst),
            .fill   (fill_flat[g*FILL_W +: FILL_W]),
            .thresh (rx_thresh[g*FILL_W +: FILL_W]),
            .ready  (rx_ready[g])
        );
    end

    rxr_readout #(.NP(NUM_PORTS), .PW(PSEL_W)) u_rd (
        .clk           (clk),
        .rst           (rst),
        .rd_en         (rd_en),
        .rd_port       (rd_port),
        .cfg_eof_both  (cfg_eof_both),
        .cfg_no_status (cfg_no_status),
        .head          (fifo_head),
        .empty         (fifo_empty),
        .pop           (fifo_pop),
        .pend_o        (stat_pend),
        .rd_data       (rd_data),
        .rd_ben_n      (rd_ben_n),
        .rd_eof        (rd_eof),
        .rd_valid      (rd_valid)
    );

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int NP = 4,
    parameter int FW = 4,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [PW-1:0] rd_port,
    input logic          rd_valid,
    input logic          rd_eof,
    input logic [3:0]    rd_ben_n,
    input logic [NP-1:0] rx_ready,
    input logic [NP-1:0] err_sticky,
    input logic [NP-1:0] fifo_empty,
    input logic [NP-1:0] stat_pend,
    input logic [NP*FW-1:0] fill_flat,
    input logic [NP*FW-1:0] rx_thresh
);
    // R1
    eof_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_eof |-> rd_valid);

    // R7
    ben_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_ben_n != 4'b1111));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fifo_empty[rd_port] && !stat_pend[rd_port]) |=> !rd_valid);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (rx_ready == '0 && !rd_valid && err_sticky == '0));

    for (genvar i = 0; i < NP; i++) begin : g_chk
        // R10
        ready_thresh_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (rx_ready[i] ==
                ($past(fill_flat[i*FW +: FW]) > $past(rx_thresh[i*FW +: FW]))));

        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(err_sticky[i])) |-> err_sticky[i]);
    end
endmodule

bind rx_frame_reader rxr_checker #(.NP(NUM_PORTS), .FW(FILL_W), .PW(PSEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_port    (rd_port),
    .rd_valid   (rd_valid),
    .rd_eof     (rd_eof),
    .rd_ben_n   (rd_ben_n),
    .rx_ready   (rx_ready),
    .err_sticky (err_sticky),
    .fifo_empty (fifo_empty),
    .stat_pend  (stat_pend),
    .fill_flat  (fill_flat),
    .rx_thresh  (rx_thresh)
);

// File: tb/tb_rx_frame_reader.sv
`timescale 1ns/1ps
module tb_rx_frame_reader;
    localparam int NP = 4;
    localparam int DEPTH = 8;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_eof_both = 1'b0;
    logic cfg_no_status = 1'b0;
    logic [NP-1:0] wr_en = '0;
    logic [NP*32-1:0] wr_data = '0;
    logic [NP*4-1:0] wr_ben_n = '0;
    logic [NP-1:0] wr_last = '0;
    logic [NP*FW-1:0] rx_thresh = {NP{4'd8}};
    logic [NP-1:0] wr_full;
    logic rd_en = 1'b0;
    logic [1:0] rd_port = '0;
    logic [31:0] rd_data;
    logic [3:0] rd_ben_n;
    logic rd_eof;
    logic rd_valid;
    logic [NP-1:0] rx_ready;
    logic [NP-1:0] err_sticky;

    rx_frame_reader #(.NUM_PORTS(NP), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_eof_both(cfg_eof_both), .cfg_no_status(cfg_no_status),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ben_n(wr_ben_n), .wr_last(wr_last),
        .rx_thresh(rx_thresh), .wr_full(wr_full), .rd_en(rd_en), .rd_port(rd_port),
        .rd_data(rd_data), .rd_ben_n(rd_ben_n), .rd_eof(rd_eof), .rd_valid(rd_valid),
        .rx_ready(rx_ready), .err_sticky(err_sticky)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  b;
        logic        e;
        string       r;
    } exp_t;

    exp_t expq [NP][$];
    int n_checks = 0;
    int n_fail = 0;
    int fid = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [3:0] tail_exp(input int rem);
        case (rem)
            1: return 4'b1110;
            2: return 4'b1100;
            3: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    // Driver: writes a frame and pushes its expected readout into the scoreboard.
    task automatic send_frame(input int p, input int nbytes, input int bad);
        int nw;
        int cnt;
        logic errf;
        exp_t e;
        nw = (nbytes + 3) / 4;
        cnt = 0;
        errf = 1'b0;
        for (int i = 0; i < nw; i++) begin
            int lb;
            lb = (i == nw - 1) ? nbytes - 4 * i : 4;
            if (i == bad) errf = 1'b1;
            else cnt += lb;
        end
        fid++;
        for (int i = 0; i < nw; i++) begin
            int lb;
            logic [3:0] bn;
            logic [31:0] d;
            lb = (i == nw - 1) ? nbytes - 4 * i : 4;
            bn = 4'b0000;
            for (int j = 0; j < 4; j++) if (j >= lb) bn[j] = 1'b1;
            if (i == bad) bn = 4'b1111;
            d = {8'(p + 8'hA0), 8'(fid), 16'(i)};
            wr_en[p] = 1'b1;
            wr_data[p*32 +: 32] = d;
            wr_ben_n[p*4 +: 4] = bn;
            wr_last[p] = (i == nw - 1);
            @(negedge clk);
            wr_en[p] = 1'b0;
            wr_last[p] = 1'b0;
            e.d = d;
            if (i == nw - 1) begin
                e.b = tail_exp(cnt % 4);
                e.e = cfg_no_status | cfg_eof_both;
                e.r = cfg_no_status ? "R5/R2" : (cfg_eof_both ? "R4/R2" : "R3/R2");
            end else begin
                e.b = 4'b0000;
                e.e = 1'b0;
                e.r = "R1";
            end
            expq[p].push_back(e);
        end
        if (!cfg_no_status) begin
            e.d = {15'b0, errf, 16'(cnt)};
            e.b = 4'b0000;
            e.e = 1'b1;
            e.r = errf ? "R6/R8" : "R6";
            expq[p].push_back(e);
        end
    endtask

    task automatic rd(input int p);
        rd_en = 1'b1;
        rd_port = 2'(p);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(input int p, input int n);
        for (int i = 0; i < n; i++) rd(p);
    endtask

    // Monitor: pops expected items as results appear.
    initial begin
        forever begin
            logic a;
            int pp;
            exp_t e;
            @(posedge clk);
            a = rd_en;
            pp = int'(rd_port);
            @(negedge clk);
            if (a && !rst) begin
                if (expq[pp].size() == 0) begin
                    chk(rd_valid === 1'b0, "R9",
                        $sformatf("empty read port %0d valid=%0b exp 0", pp, rd_valid));
                end else begin
                    e = expq[pp].pop_front();
                    chk(rd_valid === 1'b1 && rd_data === e.d && rd_ben_n === e.b && rd_eof === e.e,
                        e.r, $sformatf("port %0d valid=%0b data=%h ben=%b eof=%b exp valid=1 data=%h ben=%b eof=%b",
                        pp, rd_valid, rd_data, rd_ben_n, rd_eof, e.d, e.b, e.e));
                    chk(rd_ben_n !== 4'b1111, "R7",
                        $sformatf("ben=%b exp not 1111", rd_ben_n));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung exp done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(rd_valid === 1'b0 && rd_eof === 1'b0, "R11",
            $sformatf("valid=%0b eof=%0b exp 0 0", rd_valid, rd_eof));
        chk(rx_ready === '0 && wr_full === '0 && err_sticky === '0, "R11",
            $sformatf("ready=%b full=%b sticky=%b exp 0", rx_ready, wr_full, err_sticky));

        // R9 empty read, then the port still delivers its next frame first
        rd(3);
        send_frame(3, 4, -1);
        drain(3, 2);

        // R3 status-only tagging, R2 remainders, interleaved ports (R1)
        cfg_eof_both = 1'b0; cfg_no_status = 1'b0;
        send_frame(0, 5, -1);
        send_frame(1, 7, -1);
        send_frame(0, 8, -1);
        send_frame(1, 6, -1);
        rd(0); rd(1); rd(0); rd(1); rd(0); rd(1);
        drain(0, 3); drain(1, 3);
        send_frame(2, 1, -1);
        drain(2, 2);

        // R4 both tagged
        cfg_eof_both = 1'b1;
        send_frame(2, 9, -1);
        send_frame(0, 4, -1);
        rd(2); rd(0); rd(2); rd(0); rd(2); rd(2);
        drain(2, 1);

        // R5 no status, either position bit
        cfg_no_status = 1'b1;
        send_frame(1, 10, -1);
        drain(1, 3);
        cfg_eof_both = 1'b0;
        send_frame(1, 3, -1);
        drain(1, 2);

        // R8 illegal strobe pattern
        cfg_no_status = 1'b0;
        send_frame(1, 8, 0);
        @(negedge clk);
        chk(err_sticky === 4'b0010, "R8",
            $sformatf("sticky=%b exp 0010", err_sticky));
        drain(1, 3);
        send_frame(1, 6, -1);
        drain(1, 3);
        chk(err_sticky === 4'b0010, "R8",
            $sformatf("sticky after clean frame=%b exp 0010", err_sticky));

        // R10 watermark on port 2 with threshold 2
        rx_thresh[2*FW +: FW] = 4'd2;
        send_frame(2, 12, -1);
        @(negedge clk);
        chk(rx_ready[2] === 1'b1, "R10", $sformatf("ready=%b fill3 thr2 exp 1", rx_ready[2]));
        chk(rx_ready[0] === 1'b0, "R10", $sformatf("ready0=%b exp 0", rx_ready[0]));
        rd(2);
        @(negedge clk);
        chk(rx_ready[2] === 1'b0, "R10", $sformatf("ready=%b fill2 thr2 exp 0", rx_ready[2]));
        drain(2, 3);
        rx_thresh[2*FW +: FW] = 4'd8;

        // R12 full FIFO and dropped write
        send_frame(0, 32, -1);
        chk(wr_full[0] === 1'b1, "R12", $sformatf("full=%b exp 1", wr_full[0]));
        wr_en[0] = 1'b1; wr_data[31:0] = 32'hDEAD_BEEF; wr_ben_n[3:0] = 4'b0000; wr_last[0] = 1'b1;
        @(negedge clk);
        wr_en[0] = 1'b0; wr_last[0] = 1'b0;
        drain(0, 9);
        rd(0);
        @(negedge clk);
        chk(wr_full[0] === 1'b0, "R12", $sformatf("full after drain=%b exp 0", wr_full[0]));

        // R11 reset mid-stream clears pending data
        send_frame(3, 8, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expq[3].delete();
        @(negedge clk);
        chk(err_sticky === '0 && rx_ready === '0, "R11",
            $sformatf("sticky=%b ready=%b exp 0 0", err_sticky, rx_ready));
        rd(3);

        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(expq[p].size() == 0, "R1",
                $sformatf("port %0d unread items=%0d exp 0", p, expq[p].size()));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule